// File: doc/BRIEF.md
# Multicycle Fetch-Execute Controller

This block is a small processor core that shares one memory port between instruction fetch and data access. Every request goes through a memory address register (MAR), and every word read or written passes through a memory buffer register (MBR). A state machine takes each instruction through these steps in order: load MAR from the program counter, fetch, move to the instruction register, decode, read the operands, execute, write back, and advance the program counter. The instruction set is two-address and memory-to-memory: A = A op C, where A and C are both memory addresses.

Memory is word-addressed, with 8-bit addresses and 24-bit words. A read strobe is held for one cycle, and the read word is captured on the following cycle. A write strobe is held for one cycle and carries the data from the MBR. A status word keeps negative, zero, carry and overflow flags. A HALT instruction freezes the core until the next reset. The current state is brought out so that a testbench can time every instruction to the cycle.

States, with their `state_o` codes: LOAD_PC (0), FETCH_RD (1), FETCH_CAP (2), IR_LOAD (3), DECODE (4), OPA_RD (5), OPA_CAP (6), OPC_SET (7), OPC_RD (8), OPC_CAP (9), EXEC (10), WRITE (11), PC_INC (12), HALT (13). Transitions:
- States 0 through 4 follow each other in sequence.
- DECODE goes to OPA_RD for ADD, SUB and AND, to OPC_SET for MOV, and to HALT for HALT. Any other opcode goes to PC_INC.
- States 5 through 12 follow each other in sequence, and PC_INC returns to LOAD_PC.
- HALT stays in HALT.

Top module: `fx_core`

## Requirements
- R1: A synchronous reset clears the program counter, MAR, MBR, IR and flags. It forces state 0 (LOAD_PC). While reset is held, `mem_rd`, `mem_wr` and `halted` are low.
- R2: Each instruction starts with a read of the address held in the program counter. The instruction word is split into opcode [23:16], operand A address [15:8] and operand C address [7:0].
- R3: `mem_rd` is high for exactly one cycle per access and is never high on two consecutive cycles. The read word is taken from `mem_rdata` on the cycle after the strobe.
- R4: ADD (opcode 0x01) reads A, then reads C, then writes A+C to address A. When A and C are the same address, the same word is used for both operands.
- R5: SUB (opcode 0x02) writes A−C to address A. C is set when there is no borrow (A ≥ C unsigned), and V is set on signed overflow.
- R6: `flags_o` is {N,Z,C,V} in bits [3:0]. For ADD: N is result bit 23, Z means the result is zero, C is the carry out of bit 23, and V is signed overflow.
- R7: AND (0x03) writes A&C to address A. MOV (0x04) reads only C and writes it to A. Both update N and Z and clear C and V.
- R8: NOP (0x00) and undefined opcodes make no data read and no write. They leave the flags unchanged.
- R9: HALT (0xFF) asserts `halted` 5 cycles after LOAD_PC, keeps the flags, and issues no further strobes until reset.
- R10: The program counter advances by one only in PC_INC, after write-back. An instruction takes this many cycles from LOAD_PC back to LOAD_PC: ADD, SUB and AND take 13, MOV takes 11, and NOP and undefined opcodes take 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address, driven from MAR |
| mem_wdata | output | 24 | Write data, driven from MBR |
| mem_rdata | input | 24 | Read data, valid one cycle after `mem_rd` |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High while in HALT |
| state_o | output | 4 | Current state code |
| flags_o | output | 4 | Status word {N,Z,C,V} |

## Verification
In the EXEC cycle, three things happen at the same clock edge: the ALU result overwrites the MBR, the flags update, and MAR is reloaded with address A for the write. This is the cycle where a wrong sampling point or a stale operand would show up. The bench provokes it with directed cases (A equal to C, carry out, signed overflow from both ADD and SUB, a zero result) and with a seeded random mix of opcodes and data. For each instruction it checks the read addresses in order, the write address and data, the new flags and the cycle count against a reference model in the bench.

// File: rtl/fx_pkg.sv
package fx_pkg;
    typedef enum logic [3:0] {
        ST_LOAD_PC   = 4'd0,
        ST_FETCH_RD  = 4'd1,
        ST_FETCH_CAP = 4'd2,
        ST_IR_LOAD   = 4'd3,
        ST_DECODE    = 4'd4,
        ST_OPA_RD    = 4'd5,
        ST_OPA_CAP   = 4'd6,
        ST_OPC_SET   = 4'd7,
        ST_OPC_RD    = 4'd8,
        ST_OPC_CAP   = 4'd9,
        ST_EXEC      = 4'd10,
        ST_WRITE     = 4'd11,
        ST_PC_INC    = 4'd12,
        ST_HALT      = 4'd13
    } fx_state_t;

    localparam logic [7:0] OP_NOP  = 8'h00;
    localparam logic [7:0] OP_ADD  = 8'h01;
    localparam logic [7:0] OP_SUB  = 8'h02;
    localparam logic [7:0] OP_AND  = 8'h03;
    localparam logic [7:0] OP_MOV  = 8'h04;
    localparam logic [7:0] OP_HALT = 8'hFF;
endpackage

// File: rtl/fx_alu.sv
module fx_alu
    import fx_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic [7:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res,
    output logic [3:0]        flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] sum;
    logic            carry;
    logic            ovf;

    always_comb begin
        sum   = '0;
        res   = '0;
        carry = 1'b0;
        ovf   = 1'b0;
        unique case (op)
            OP_ADD: begin
                sum   = {1'b0, a} + {1'b0, b};
                res   = sum[MSB:0];
                carry = sum[DATA_W];
                ovf   = (a[MSB] == b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_SUB: begin
                sum   = {1'b0, a} + {1'b0, ~b} + (DATA_W+1)'(1);
                res   = sum[MSB:0];
                carry = sum[DATA_W];
                ovf   = (a[MSB] != b[MSB]) && (res[MSB] != a[MSB]);
            end
            OP_AND:  res = a & b;
            OP_MOV:  res = b;
            default: res = '0;
        endcase
        flags = {res[MSB], (res == '0), carry, ovf};
    end
endmodule

// File: rtl/fx_ctrl.sv
module fx_ctrl
    import fx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [7:0] opcode,
    output fx_state_t state,
    output logic      mem_rd,
    output logic      mem_wr,
    output logic      halted
);
    fx_state_t nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_LOAD_PC;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD_PC:   nxt = ST_FETCH_RD;
            ST_FETCH_RD:  nxt = ST_FETCH_CAP;
            ST_FETCH_CAP: nxt = ST_IR_LOAD;
            ST_IR_LOAD:   nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_ADD || opcode == OP_SUB || opcode == OP_AND)
                    nxt = ST_OPA_RD;
                else if (opcode == OP_MOV)  nxt = ST_OPC_SET;
                else if (opcode == OP_HALT) nxt = ST_HALT;
                else                        nxt = ST_PC_INC;
            end
            ST_OPA_RD:    nxt = ST_OPA_CAP;
            ST_OPA_CAP:   nxt = ST_OPC_SET;
            ST_OPC_SET:   nxt = ST_OPC_RD;
            ST_OPC_RD:    nxt = ST_OPC_CAP;
            ST_OPC_CAP:   nxt = ST_EXEC;
            ST_EXEC:      nxt = ST_WRITE;
            ST_WRITE:     nxt = ST_PC_INC;
            ST_PC_INC:    nxt = ST_LOAD_PC;
            ST_HALT:      nxt = ST_HALT;
            default:      nxt = ST_LOAD_PC;
        endcase
    end

    always_comb begin
        mem_rd = 1'b0;
        mem_wr = 1'b0;
        halted = 1'b0;
        unique case (state)
            ST_FETCH_RD, ST_OPA_RD, ST_OPC_RD: mem_rd = 1'b1;
            ST_WRITE:                          mem_wr = 1'b1;
            ST_HALT:                           halted = 1'b1;
            default: ;
        endcase
    end

    logic chk_ok;
    always_ff @(posedge clk) begin
        if (rst) chk_ok <= 1'b0;
        else     chk_ok <= 1'b1;
    end

    p_rd_single_r3: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && mem_rd) |=> !mem_rd);
    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && halted) |=> (halted && !mem_rd && !mem_wr));
    p_wr_after_exec_r10: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && mem_wr) |-> ($past(state) == ST_EXEC));
endmodule

// File: rtl/fx_core.sv
module fx_core
    import fx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              halted,
    output logic [3:0]        state_o,
    output logic [3:0]        flags_o
);
    localparam int OP_W = DATA_W - 2 * ADDR_W;

    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] mbr_q, ir_q, opa_q;
    logic [3:0]        flags_q;
    logic [7:0]        opcode;
    logic [ADDR_W-1:0] addr_a, addr_c;
    logic [DATA_W-1:0] alu_res;
    logic [3:0]        alu_flags;
    fx_state_t         state;

    assign opcode = 8'(ir_q[DATA_W-1 -: OP_W]);
    assign addr_a = ir_q[2*ADDR_W-1 -: ADDR_W];
    assign addr_c = ir_q[ADDR_W-1:0];

    fx_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .state  (state),
        .mem_rd (mem_rd),
        .mem_wr (mem_wr),
        .halted (halted)
    );

    fx_alu #(.DATA_W(DATA_W)) u_alu (
        .op    (opcode),
        .a     (opa_q),
        .b     (mbr_q),
        .res   (alu_res),
        .flags (alu_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            mar_q   <= '0;
            mbr_q   <= '0;
            ir_q    <= '0;
            opa_q   <= '0;
            flags_q <= '0;
        end else begin
            unique case (state)
                ST_LOAD_PC: mar_q <= pc_q;
                ST_FETCH_CAP, ST_OPA_CAP, ST_OPC_CAP: mbr_q <= mem_rdata;
                ST_IR_LOAD: ir_q  <= mbr_q;
                ST_DECODE:  mar_q <= addr_a;
                ST_OPC_SET: begin
                    opa_q <= mbr_q;
                    mar_q <= addr_c;
                end
                ST_EXEC: begin
                    mbr_q   <= alu_res;
                    flags_q <= alu_flags;
                    mar_q   <= addr_a;
                end
                ST_PC_INC:  pc_q <= pc_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign mem_addr  = mar_q;
    assign mem_wdata = mbr_q;
    assign state_o   = state;
    assign flags_o   = flags_q;

    logic chk_ok;
    always_ff @(posedge clk) begin
        if (rst) chk_ok <= 1'b0;
        else     chk_ok <= 1'b1;
    end

    p_mar_from_pc_r2: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && state == ST_LOAD_PC) |=> (mem_addr == $past(pc_q)));
    p_ir_from_mbr_r2: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && state == ST_IR_LOAD) |=> (ir_q == $past(mbr_q)));
    p_pc_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && state != ST_PC_INC) |=> $stable(pc_q));
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && state != ST_EXEC) |=> $stable(flags_o));
    p_wr_addr_a_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_ok && mem_wr) |-> (mem_addr == addr_a));
endmodule

// File: tb/test_fx_core.sv
`timescale 1ns/1ps
module test_fx_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata;
    logic        mem_rd, mem_wr, halted;
    logic [3:0]  state_o, flags_o;

    logic [23:0] mem [256];
    int          tests = 0;
    int          fails = 0;
    logic [7:0]  pc_ref;
    logic [3:0]  fl_ref;

    always #5 clk = ~clk;

    fx_core i_fx_core (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .halted(halted), .state_o(state_o), .flags_o(flags_o)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [27:0] ref_exec(input logic [7:0] op,
            input logic [23:0] a, input logic [23:0] c, input logic [3:0] fl);
        logic [24:0] s;
        logic [23:0] r;
        logic        cy, ov;
        s = '0; cy = 1'b0; ov = 1'b0; r = '0;
        case (op)
            8'h01: begin
                s = {1'b0, a} + {1'b0, c}; r = s[23:0]; cy = s[24];
                ov = (a[23] == c[23]) && (r[23] != a[23]);
            end
            8'h02: begin
                s = {1'b0, a} - {1'b0, c}; r = s[23:0]; cy = (a >= c);
                ov = (a[23] != c[23]) && (r[23] != a[23]);
            end
            8'h03: r = a & c;
            8'h04: r = c;
            default: return {fl, 24'h0};
        endcase
        return {r[23], (r == 24'h0), cy, ov, r};
    endfunction

    task automatic run_instr(input logic [7:0] op, input logic [7:0] a,
                             input logic [7:0] c, input logic [23:0] da,
                             input logic [23:0] dc);
        logic [23:0] va, vc;
        logic [27:0] rf;
        logic [7:0]  rd_addr [4];
        logic [7:0]  exp_rd [3];
        logic [7:0]  wa;
        logic [23:0] wd;
        int nrd, nwr, cyc, exp_cyc, exp_nrd, back2back;
        logic prev_rd;
        bit is_alu, is_mov;
        string rq;
        mem[pc_ref] = {op, a, c};
        mem[a] = da;
        mem[c] = dc;
        va = mem[a]; vc = mem[c];
        is_alu = (op == 8'h01 || op == 8'h02 || op == 8'h03);
        is_mov = (op == 8'h04);
        rq = (op == 8'h01) ? "R4" : (op == 8'h02) ? "R5" : (is_alu || is_mov) ? "R7" : "R8";
        exp_cyc = is_alu ? 13 : is_mov ? 11 : 6;
        exp_rd[0] = pc_ref;
        exp_rd[1] = is_alu ? a : c;
        exp_rd[2] = c;
        exp_nrd = is_alu ? 3 : is_mov ? 2 : 1;
        rf = ref_exec(op, va, vc, fl_ref);
        nrd = 0; nwr = 0; cyc = 0; back2back = 0; prev_rd = 1'b0;
        wa = '0; wd = '0;
        forever begin
            if (mem_rd) begin
                if (nrd < 4) rd_addr[nrd] = mem_addr;
                nrd++;
                if (prev_rd) back2back++;
            end
            prev_rd = mem_rd;
            if (mem_wr) begin wa = mem_addr; wd = mem_wdata; nwr++; end
            @(negedge clk);
            cyc++;
            if (state_o == 4'd0 || cyc >= 40) break;
        end
        chk("R10", "cycles per instruction", cyc, exp_cyc);
        chk("R3", "back-to-back read strobes", back2back, 0);
        chk(rq, "read count", nrd, exp_nrd);
        if (nrd >= 1) chk("R2", "fetch address equals PC", rd_addr[0], exp_rd[0]);
        for (int k = 1; k < exp_nrd && k < nrd; k++)
            chk(rq, "operand read address", rd_addr[k], exp_rd[k]);
        if (is_alu || is_mov) begin
            chk(rq, "write count", nwr, 1);
            chk(rq, "write address", wa, a);
            chk(rq, "write data", wd, rf[23:0]);
        end else begin
            chk("R8", "no write", nwr, 0);
        end
        chk((op == 8'h01 || op == 8'h02) ? "R6" : rq, "flags", flags_o, rf[27:24]);
        fl_ref = rf[27:24];
        pc_ref = pc_ref + 8'd1;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] ops [7];
        void'($urandom(32'd20240611));
        ops[0] = 8'h01; ops[1] = 8'h02; ops[2] = 8'h03; ops[3] = 8'h04;
        ops[4] = 8'h00; ops[5] = 8'h37; ops[6] = 8'h01;
        for (int i = 0; i < 256; i++) mem[i] = 24'h0;
        pc_ref = 8'h0; fl_ref = 4'h0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "reset state", state_o, 4'd0);
        chk("R1", "reset flags", flags_o, 4'h0);
        chk("R1", "reset halted", halted, 1'b0);
        chk("R1", "reset strobes", {mem_rd, mem_wr}, 2'b00);
        rst = 1'b0;

        // directed corner cases
        run_instr(8'h01, 8'h80, 8'h81, 24'h7FFFFF, 24'h000001); // R6 overflow, N
        run_instr(8'h01, 8'h82, 8'h83, 24'hFFFFFF, 24'h000001); // R6 carry, zero
        run_instr(8'h02, 8'h84, 8'h85, 24'h001234, 24'h001234); // R5 equal
        run_instr(8'h02, 8'h86, 8'h87, 24'h000000, 24'h000001); // R5 borrow
        run_instr(8'h02, 8'h88, 8'h89, 24'h800000, 24'h000001); // R5 overflow
        run_instr(8'h01, 8'h8A, 8'h8A, 24'h0, 24'h400001);      // R4 A equals C
        run_instr(8'h03, 8'h8B, 8'h8C, 24'hF0F0F0, 24'h0F0F00); // R7 and to zero
        run_instr(8'h04, 8'h8D, 8'h8E, 24'h123456, 24'h900000); // R7 move
        run_instr(8'h00, 8'h8F, 8'h90, 24'h1, 24'h2);           // R8 nop
        run_instr(8'h37, 8'h91, 8'h92, 24'h1, 24'h2);           // R8 undefined

        for (int i = 0; i < 60; i++) begin
            logic [7:0] a, c;
            a = 8'h80 | 8'($urandom % 128);
            c = ((($urandom % 5) == 0)) ? a : (8'h80 | 8'($urandom % 128));
            run_instr(ops[$urandom % 7], a, c, 24'($urandom), 24'($urandom));
        end

        // R9 halt
        mem[pc_ref] = 24'hFF_0000;
        repeat (5) @(negedge clk);
        chk("R9", "halt state", state_o, 4'd13);
        chk("R9", "halted asserted", halted, 1'b1);
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (mem_rd || mem_wr || !halted) bad++;
            end
            chk("R9", "quiet while halted", bad, 0);
        end
        chk("R9", "flags kept on halt", flags_o, fl_ref);

        // R1 reset leaves halt and restarts at address 0
        rst = 1'b1;
        @(negedge clk);
        chk("R1", "reset clears halted", halted, 1'b0);
        chk("R1", "reset clears flags", flags_o, 4'h0);
        chk("R1", "reset state after halt", state_o, 4'd0);
        rst = 1'b0;
        pc_ref = 8'h0; fl_ref = 4'h0;
        run_instr(8'h01, 8'hA0, 8'hA1, 24'h000010, 24'h000020);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule